// File: doc/BRIEF.md
# Big-Endian ATA Register Front-End

This block sits between a 32-bit big-endian memory-mapped bus and the register file of a parallel ATA channel. Each bus access carries an address, a size (byte, halfword or word), a direction and write data. The block turns this into single-cycle strobes towards the task-file registers, the alternate-status/device-control pair and the data port. It holds a local timing register and a local interrupt-state register, and it returns read data one cycle after the request.

Registers are placed 16 bytes apart inside a 4 KB window, so the register index is taken from address bits 11:4. Everything above and below that field only aliases. Byte accesses reach the 8-bit task file and the alternate-status/device-control register, which appears at two indexes. Halfword and word accesses reach the data port. Word accesses also reach the timing and interrupt-state registers. Every wide value is byte-reversed on its way through, so that a little-endian drive appears in natural order to a big-endian host.

The interrupt-state register shows two interrupt sources. The DMA-completion bit latches on a rising level, drops on a falling level, and can also be cleared by software writing a one. The drive bit is a live, one-cycle-delayed image of the drive interrupt. Both interrupt inputs are also passed straight through to their own output pins.

Top module: `ata_be_regif`

## Requirements
- R1: The register index is addr[11:4]; addr[3:0] and address bits above 11 never change which register is reached, and at most one downstream strobe is active per cycle.
- R2: A byte access at index 1 to 7 pulses tf_rd or tf_wr in the request cycle with tf_idx equal to the index and tf_wdata equal to wdata[7:0]; a byte read returns tf_rdata in rdata[7:0] with rdata[31:8] zero.
- R3: A byte access at index 8 or index 22 reads alt_rdata (alt_rd pulse) or writes wdata[7:0] to device control (ctl_wr pulse).
- R4: A read that maps to nothing returns all ones in the access width (byte 0x000000FF, halfword 0x0000FFFF, word 0xFFFFFFFF); a write that maps to nothing raises no strobe and changes no register; size code 3 is reserved, raises no strobe and reads as 0.
- R5: A halfword access at index 0 is a data-port access with dp_wide low; dp_wdata[15:0] is wdata[15:0] with its two bytes exchanged and dp_wdata[31:16] zero, and the read result is dp_rdata[15:0] with its bytes exchanged.
- R6: A word access at index 0 is a data-port access with dp_wide high; write and read values are fully byte-reversed (byte 0 with byte 3, byte 1 with byte 2).
- R7: Index 0x20 holds a 32-bit timing register; a word write stores it and a word read returns the last value written in bus order; no other access changes it.
- R8: A word read at index 0x30 returns the interrupt state with rdata[7] the DMA bit, rdata[6] the drive bit and every other bit zero.
- R9: The DMA bit sets in the cycle after dma_irq_i rises and clears after it falls; a word write at index 0x30 with wdata[7] set clears it while the input is steady; writes with wdata[7] clear do nothing; a rise in the same cycle as a clearing write leaves the bit set.
- R10: The drive bit equals drv_irq_i from the previous cycle and no write changes it.
- R11: dma_irq_o follows dma_irq_i and drv_irq_o follows drv_irq_i with no register between.
- R12: rdata and rvalid update at the clock edge that ends a read request; rvalid is high for exactly that one cycle; halfword and word accesses at indexes 1 to 7 never strobe the task file.
- R13: Reset clears the timing register, both interrupt-state bits and rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Bus access request, one cycle per access |
| we | input | 1 | 1 for write, 0 for read |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data, bus byte order |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid |
| tf_idx | output | 3 | Task-file register number |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_wdata | output | 8 | Task-file write data |
| tf_rdata | input | 8 | Task-file read data |
| ctl_wr | output | 1 | Device-control write strobe |
| ctl_wdata | output | 8 | Device-control write data |
| alt_rd | output | 1 | Alternate-status read strobe |
| alt_rdata | input | 8 | Alternate-status value |
| dp_rd | output | 1 | Data-port read strobe |
| dp_wr | output | 1 | Data-port write strobe |
| dp_wide | output | 1 | Data-port access is 32-bit |
| dp_wdata | output | 32 | Data-port write data, drive byte order |
| dp_rdata | input | 32 | Data-port read data, drive byte order |
| dma_irq_i | input | 1 | DMA interrupt level |
| drv_irq_i | input | 1 | Drive interrupt level |
| dma_irq_o | output | 1 | Forwarded DMA interrupt |
| drv_irq_o | output | 1 | Forwarded drive interrupt |

## Verification
The hardest case is the race between a software clear and a fresh DMA rising edge in the same cycle, together with a clear issued while the DMA input is still held high. Both need the interrupt input to be moved on exactly the cycle of a bus write. The bench does this with directed sequences that drive the interrupt level and the clearing write on the same falling clock edge, and then reads the state register back over the bus. Aliasing is covered by random stimulus that fills the ignored low and high address bits.

// File: rtl/ata_be_pkg.sv
package ata_be_pkg;

  localparam int WIN_BITS  = 12;
  localparam int SLOT_BITS = 4;
  localparam int IDX_W     = WIN_BITS - SLOT_BITS;
  localparam int BUS_W     = 32;
  localparam int BUS_LANES = BUS_W / 8;

  localparam logic [IDX_W-1:0] IDX_DATA   = 8'h00;
  localparam logic [IDX_W-1:0] IDX_TF_LO  = 8'h01;
  localparam logic [IDX_W-1:0] IDX_TF_HI  = 8'h07;
  localparam logic [IDX_W-1:0] IDX_ALT_A  = 8'h08;
  localparam logic [IDX_W-1:0] IDX_ALT_B  = 8'h16;
  localparam logic [IDX_W-1:0] IDX_TIMING = 8'h20;
  localparam logic [IDX_W-1:0] IDX_IRQ    = 8'h30;

  localparam int IRQ_N   = 2;
  localparam int IRQ_DMA = 0;
  localparam int IRQ_DRV = 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_TASKFILE,
    TGT_ALTCTL,
    TGT_DATA,
    TGT_TIMING,
    TGT_IRQ
  } tgt_e;

endpackage

// File: rtl/ata_be_decode.sv
module ata_be_decode
  import ata_be_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx
);

  localparam int IDX_MSB = WIN_BITS - 1;

  assign idx = addr[IDX_MSB:SLOT_BITS];

  always_comb begin
    tgt = TGT_NONE;
    case (size)
      SZ_BYTE: begin
        if (idx >= IDX_TF_LO && idx <= IDX_TF_HI) begin
          tgt = TGT_TASKFILE;
        end else if (idx == IDX_ALT_A || idx == IDX_ALT_B) begin
          tgt = TGT_ALTCTL;
        end
      end
      SZ_HALF: begin
        if (idx == IDX_DATA) begin
          tgt = TGT_DATA;
        end
      end
      SZ_WORD: begin
        if (idx == IDX_DATA) begin
          tgt = TGT_DATA;
        end else if (idx == IDX_TIMING) begin
          tgt = TGT_TIMING;
        end else if (idx == IDX_IRQ) begin
          tgt = TGT_IRQ;
        end
      end
      default: tgt = TGT_NONE;
    endcase
  end

endmodule

// File: rtl/ata_be_bswap.sv
module ata_be_bswap #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] din,
  output logic [8*LANES-1:0] dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[8*g +: 8] = din[8*(LANES-1-g) +: 8];
  end

endmodule

// File: rtl/ata_be_irqstat.sv
module ata_be_irqstat #(
  parameter int                N         = 2,
  parameter logic [N-1:0]      CLR_MASK  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] clr,
  output logic [N-1:0] state
);

  logic [N-1:0] prev_q, prev_d;
  logic [N-1:0] state_q, state_d;

  for (genvar n = 0; n < N; n++) begin : g_chan
    always_comb begin
      state_d[n] = state_q[n];
      if (lvl[n] != prev_q[n]) begin
        state_d[n] = lvl[n];
      end else if (CLR_MASK[n] && clr[n]) begin
        state_d[n] = 1'b0;
      end
    end
  end

  assign prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      state_q <= '0;
    end else begin
      prev_q  <= prev_d;
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/ata_be_regif.sv
module ata_be_regif
  import ata_be_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic [2:0]        tf_idx,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic [7:0]        tf_wdata,
  input  logic [7:0]        tf_rdata,
  output logic              ctl_wr,
  output logic [7:0]        ctl_wdata,
  output logic              alt_rd,
  input  logic [7:0]        alt_rdata,
  output logic              dp_rd,
  output logic              dp_wr,
  output logic              dp_wide,
  output logic [31:0]       dp_wdata,
  input  logic [31:0]       dp_rdata,
  input  logic              dma_irq_i,
  input  logic              drv_irq_i,
  output logic              dma_irq_o,
  output logic              drv_irq_o
);

  localparam int HALF_W    = BUS_W / 2;
  localparam int HALF_LN   = BUS_LANES / 2;
  localparam int TF_IDX_W  = 3;

  tgt_e             tgt;
  logic [IDX_W-1:0] idx;
  logic             acc_rd, acc_wr;
  logic [BUS_W-1:0] wsw_word, rsw_word, rd_word_raw;
  logic [HALF_W-1:0] wsw_half, rsw_half;
  logic [BUS_W-1:0] timing_q, timing_d;
  logic             tim_en;
  logic [BUS_W-1:0] rdata_q, rdata_d;
  logic             rvalid_q, rvalid_d;
  logic [IRQ_N-1:0] irq_lvl, irq_clr, irq_state;
  logic [BUS_W-1:0] irq_word;
  logic             dma_bit, drv_bit;

  ata_be_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .size (size),
    .tgt  (tgt),
    .idx  (idx)
  );

  ata_be_bswap #(.LANES(BUS_LANES)) u_wswap_w (.din(wdata), .dout(wsw_word));
  ata_be_bswap #(.LANES(HALF_LN))   u_wswap_h (.din(wdata[HALF_W-1:0]), .dout(wsw_half));
  ata_be_bswap #(.LANES(BUS_LANES)) u_rswap_w (.din(rd_word_raw), .dout(rsw_word));
  ata_be_bswap #(.LANES(HALF_LN))   u_rswap_h (.din(dp_rdata[HALF_W-1:0]), .dout(rsw_half));

  assign acc_rd = req && !we;
  assign acc_wr = req && we;

  // downstream strobes
  assign tf_idx    = idx[TF_IDX_W-1:0];
  assign tf_rd     = acc_rd && (tgt == TGT_TASKFILE);
  assign tf_wr     = acc_wr && (tgt == TGT_TASKFILE);
  assign tf_wdata  = wdata[7:0];
  assign alt_rd    = acc_rd && (tgt == TGT_ALTCTL);
  assign ctl_wr    = acc_wr && (tgt == TGT_ALTCTL);
  assign ctl_wdata = wdata[7:0];
  assign dp_rd     = acc_rd && (tgt == TGT_DATA);
  assign dp_wr     = acc_wr && (tgt == TGT_DATA);
  assign dp_wide   = (size == SZ_WORD);
  assign dp_wdata  = dp_wide ? wsw_word : {{HALF_W{1'b0}}, wsw_half};

  // interrupt state
  always_comb begin
    irq_lvl          = '0;
    irq_lvl[IRQ_DMA] = dma_irq_i;
    irq_lvl[IRQ_DRV] = drv_irq_i;
    irq_clr          = '0;
    irq_clr[IRQ_DMA] = acc_wr && (tgt == TGT_IRQ) && wsw_word[BUS_W-1];
  end

  ata_be_irqstat #(
    .N        (IRQ_N),
    .CLR_MASK (2'b01)
  ) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (irq_lvl),
    .clr   (irq_clr),
    .state (irq_state)
  );

  for (genvar n = 0; n < BUS_W; n++) begin : g_irqw
    if (n >= BUS_W - IRQ_N) begin : g_live
      assign irq_word[n] = irq_state[BUS_W-1-n];
    end else begin : g_zero
      assign irq_word[n] = 1'b0;
    end
  end

  assign dma_bit   = irq_state[IRQ_DMA];
  assign drv_bit   = irq_state[IRQ_DRV];
  assign dma_irq_o = dma_irq_i;
  assign drv_irq_o = drv_irq_i;

  // timing register
  assign tim_en = acc_wr && (tgt == TGT_TIMING);

  always_comb begin
    timing_d = timing_q;
    if (tim_en) begin
      timing_d = wsw_word;
    end
  end

  // read path
  always_comb begin
    case (tgt)
      TGT_TIMING: rd_word_raw = timing_q;
      TGT_IRQ:    rd_word_raw = irq_word;
      default:    rd_word_raw = dp_rdata;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (acc_rd) begin
      case (tgt)
        TGT_TASKFILE: rdata_d = {{(BUS_W-8){1'b0}}, tf_rdata};
        TGT_ALTCTL:   rdata_d = {{(BUS_W-8){1'b0}}, alt_rdata};
        TGT_DATA: begin
          if (size == SZ_HALF) begin
            rdata_d = {{HALF_W{1'b0}}, rsw_half};
          end else begin
            rdata_d = rsw_word;
          end
        end
        TGT_TIMING,
        TGT_IRQ:      rdata_d = rsw_word;
        default: begin
          case (size)
            SZ_BYTE: rdata_d = {{(BUS_W-8){1'b0}}, 8'hFF};
            SZ_HALF: rdata_d = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            SZ_WORD: rdata_d = {BUS_W{1'b1}};
            default: rdata_d = '0;
          endcase
        end
      endcase
    end
  end

  assign rvalid_d = acc_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      timing_q <= timing_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/ata_be_regif_chk.sv
module ata_be_regif_chk
  import ata_be_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [1:0]        size,
  input logic [ADDR_W-1:0] addr,
  input logic              tf_rd,
  input logic              tf_wr,
  input logic              ctl_wr,
  input logic              alt_rd,
  input logic              dp_rd,
  input logic              dp_wr,
  input logic              dp_wide,
  input logic              rvalid,
  input logic              dma_irq_i,
  input logic              drv_irq_i,
  input logic              dma_bit,
  input logic              drv_bit,
  input logic [31:0]       timing_q
);

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tf_rd, tf_wr, ctl_wr, alt_rd, dp_rd, dp_wr}));

  // R12
  tf_byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size != SZ_BYTE) |-> !(tf_rd || tf_wr));

  // R4
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_RSVD) |-> !(tf_rd || tf_wr || ctl_wr || alt_rd || dp_rd || dp_wr));

  // R6
  dp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd || dp_wr) |-> (dp_wide == (size == SZ_WORD)));

  // R12
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid);

  // R12
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid);

  // R9
  dma_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_irq_i |=> !dma_bit);

  // R10
  drv_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_irq_i |=> drv_bit);

  // R10
  drv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_irq_i |=> !drv_bit);

  // R7
  timing_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && we && size == SZ_WORD && addr[WIN_BITS-1:SLOT_BITS] == IDX_TIMING)
      |=> $stable(timing_q));

endmodule

bind ata_be_regif ata_be_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .we        (we),
  .size      (size),
  .addr      (addr),
  .tf_rd     (tf_rd),
  .tf_wr     (tf_wr),
  .ctl_wr    (ctl_wr),
  .alt_rd    (alt_rd),
  .dp_rd     (dp_rd),
  .dp_wr     (dp_wr),
  .dp_wide   (dp_wide),
  .rvalid    (rvalid),
  .dma_irq_i (dma_irq_i),
  .drv_irq_i (drv_irq_i),
  .dma_bit   (dma_bit),
  .drv_bit   (drv_bit),
  .timing_q  (timing_q)
);

// File: tb/ata_be_regif_tb.sv
`timescale 1ns/1ps
module ata_be_regif_tb;

  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req, we;
  logic [1:0]        size;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata, rdata, dp_wdata, dp_rdata;
  logic              rvalid;
  logic [2:0]        tf_idx;
  logic              tf_rd, tf_wr, ctl_wr, alt_rd, dp_rd, dp_wr, dp_wide;
  logic [7:0]        tf_wdata, tf_rdata, ctl_wdata, alt_rdata;
  logic              dma_irq_i, drv_irq_i, dma_irq_o, drv_irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] tim_m;
  bit          dma_m, drv_m;

  always #5 clk = ~clk;

  assign tf_rdata  = {5'b10110, tf_idx};
  assign alt_rdata = 8'h5C;

  ata_be_regif #(.ADDR_W(ADDR_W)) u_dut (.*);

  function automatic logic [31:0] sw32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [15:0] sw16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus access: drive at negedge, check strobes, check read data after the edge
  task automatic acc(input bit w, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                     input logic [31:0] wd, input string tag);
    logic [7:0]  ix;
    logic [5:0]  exp_stb, act_stb;
    logic [31:0] exp_rd, exp_dpw;
    ix = a[11:4];
    exp_stb = '0;
    exp_rd  = 32'h0;
    exp_dpw = 32'h0;
    @(negedge clk);
    dp_rdata = $urandom;
    req = 1'b1; we = w; size = sz; addr = a; wdata = wd;
    if (sz == 2'd0 && ix >= 8'd1 && ix <= 8'd7) begin
      exp_stb = w ? 6'b010000 : 6'b100000;
      exp_rd  = {24'h0, 5'b10110, ix[2:0]};
    end else if (sz == 2'd0 && (ix == 8'd8 || ix == 8'd22)) begin
      exp_stb = w ? 6'b001000 : 6'b000100;
      exp_rd  = 32'h5C;
    end else if ((sz == 2'd1 || sz == 2'd2) && ix == 8'd0) begin
      exp_stb = w ? 6'b000001 : 6'b000010;
      exp_rd  = (sz == 2'd1) ? {16'h0, sw16(dp_rdata[15:0])} : sw32(dp_rdata);
      exp_dpw = (sz == 2'd1) ? {16'h0, sw16(wd[15:0])} : sw32(wd);
    end else if (sz == 2'd2 && ix == 8'h20) begin
      exp_rd = sw32(tim_m);
    end else if (sz == 2'd2 && ix == 8'h30) begin
      exp_rd = {24'h0, dma_m, drv_m, 6'h0};
    end else begin
      exp_rd = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF :
               (sz == 2'd2) ? 32'hFFFF_FFFF : 32'h0;
    end
    #1;
    act_stb = {tf_rd, tf_wr, ctl_wr, alt_rd, dp_rd, dp_wr};
    check(act_stb == exp_stb, {tag, " strobes"}, {26'h0, act_stb}, {26'h0, exp_stb});
    if (exp_stb[5] || exp_stb[4])
      check(tf_idx == ix[2:0] && (!w || tf_wdata == wd[7:0]), {tag, " R2 tf fields"},
            {21'h0, tf_idx, tf_wdata}, {21'h0, ix[2:0], wd[7:0]});
    if (exp_stb[3])
      check(ctl_wdata == wd[7:0], {tag, " R3 ctl data"}, {24'h0, ctl_wdata}, {24'h0, wd[7:0]});
    if (exp_stb[1] || exp_stb[0])
      check(dp_wide == (sz == 2'd2), {tag, " R6 dp_wide"}, {31'h0, dp_wide}, {31'h0, sz == 2'd2});
    if (exp_stb[0])
      check(dp_wdata == exp_dpw, {tag, " R5 R6 dp_wdata"}, dp_wdata, exp_dpw);
    @(negedge clk);
    req = 1'b0;
    check(rvalid == !w, {tag, " R12 rvalid"}, {31'h0, rvalid}, {31'h0, !w});
    if (!w) check(rdata == exp_rd, {tag, " rdata"}, rdata, exp_rd);
    if (w && sz == 2'd2 && ix == 8'h20) tim_m = sw32(wd);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pick [12];
    pick = '{8'h00, 8'h01, 8'h04, 8'h07, 8'h08, 8'h16, 8'h20, 8'h30, 8'h09, 8'h17, 8'h21, 8'hFF};
    void'($urandom(32'd1234));
    rst_n = 1'b0; req = 0; we = 0; size = 0; addr = 0; wdata = 0; dp_rdata = 0;
    dma_irq_i = 0; drv_irq_i = 0;
    tim_m = 0; dma_m = 0; drv_m = 0;
    repeat (3) @(negedge clk);
    check(rvalid == 1'b0, "R13 rvalid at reset", {31'h0, rvalid}, 32'h0);
    rst_n = 1'b1;

    // R13 reset state
    acc(0, 2'd2, 16'h0200, 0, "R13 timing reset");
    acc(0, 2'd2, 16'h0300, 0, "R13 irq reset");

    // R7 timing write/read, aliased address R1
    acc(1, 2'd2, 16'h0200, 32'hA1B2C3D4, "R7 timing wr");
    acc(0, 2'd2, 16'hF20C, 0, "R7 R1 timing rd alias");
    // R12 wide access at task-file index
    acc(1, 2'd2, 16'h0030, 32'h12345678, "R12 word at tf");
    acc(0, 2'd1, 16'h0070, 0, "R12 half at tf");
    // R4 unmapped / reserved
    acc(0, 2'd0, 16'h0090, 0, "R4 byte unmapped");
    acc(0, 2'd1, 16'h0080, 0, "R4 half unmapped");
    acc(0, 2'd2, 16'h0040, 0, "R4 word unmapped");
    acc(1, 2'd2, 16'h0210, 32'hDEADBEEF, "R4 wr unmapped");
    acc(0, 2'd3, 16'h0010, 0, "R4 reserved size");
    acc(0, 2'd2, 16'h0200, 0, "R4 R7 timing kept");
    // R3 both alias indexes, R2, R5, R6
    acc(0, 2'd0, 16'h0160, 0, "R3 alt idx22");
    acc(1, 2'd0, 16'h0085, 32'h0000_0004, "R3 ctl idx8");
    acc(1, 2'd0, 16'h0010, 32'h0000_00A5, "R2 tf wr");
    acc(0, 2'd0, 16'h0070, 0, "R2 tf rd");
    acc(1, 2'd1, 16'h0002, 32'hFFFF_1234, "R5 half wr");
    acc(0, 2'd1, 16'h0000, 0, "R5 half rd");
    acc(1, 2'd2, 16'h0000, 32'h0102_0304, "R6 word wr");
    acc(0, 2'd2, 16'h0000, 0, "R6 word rd");

    // R11 forwarding
    @(negedge clk); dma_irq_i = 1; drv_irq_i = 1; #1;
    check(dma_irq_o && drv_irq_o, "R11 forward high", {30'h0, dma_irq_o, drv_irq_o}, 32'h3);
    dma_m = 1; drv_m = 1;
    acc(0, 2'd2, 16'h0300, 0, "R8 R9 R10 both set");
    // R9 write without bit 7 is ignored, R10 drive not cleared
    acc(1, 2'd2, 16'h0300, 32'h0000_007F, "R9 no-clear wr");
    acc(0, 2'd2, 16'h0300, 0, "R9 R10 still set");
    acc(1, 2'd2, 16'h0300, 32'h0000_0080, "R9 w1c");
    dma_m = 0;
    acc(0, 2'd2, 16'h0300, 0, "R9 R10 cleared dma only");
    // R9 fall then rise same cycle as clear write
    @(negedge clk); dma_irq_i = 0; drv_irq_i = 0; #1;
    check(!dma_irq_o && !drv_irq_o, "R11 forward low", {30'h0, dma_irq_o, drv_irq_o}, 32'h0);
    drv_m = 0;
    @(negedge clk);
    dma_irq_i = 1; req = 1; we = 1; size = 2'd2; addr = 16'h0300; wdata = 32'hFFFF_FFFF;
    @(negedge clk); req = 0;
    dma_m = 1;
    acc(0, 2'd2, 16'h0300, 0, "R9 rise beats clear");
    @(negedge clk); dma_irq_i = 0;
    dma_m = 0;
    acc(0, 2'd2, 16'h0300, 0, "R9 fall clears");

    // random mix, R1 aliasing through random upper/lower address bits
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  ix;
      logic [ADDR_W-1:0] a;
      ix = pick[$urandom_range(0, 11)];
      a  = {4'($urandom), ix, 4'($urandom)};
      acc(1'($urandom), 2'($urandom), a, $urandom, "R1 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule